// File: doc/BRIEF.md
# Propagation-Delay Slope Calibrator

This block tunes the edge speed of a single-wire bus transmitter so that the delay from a transmit-data edge to the echoed receive-data edge stays under a limit. Each time the transmit line changes level, a measurement opens. It closes when the receive line reaches the new level. A counter runs alongside the open measurement. If the measurement is still open when the counter reaches its threshold, a detect pulse fires. That pulse adds one more enable to a thermometer-coded vector, and the vector switches on slope-current cells in the analog driver.

A strong driver gives short delays, so the detect pulses stop and the vector keeps its setting. If the echo never returns, a watchdog inside the measurement closes it at four times the threshold, and that also counts as a detect. A calibration enable input gates the whole loop. Reset returns the vector to zero cells.

The threshold is 2^CNT_W clock cycles and can be set to the maximum allowed propagation delay (for example 6 us). The vector holds CELLS enables. Both inputs are expected to be synchronous to `clk`. There is no data stream here, so every pin is a plain level or pulse and none carries a handshake.

Top module: `slope_delay_servo`

## Requirements
- R1: While reset is low and in the first cycle after it, `slope_en` is all zeros and `saturated` and `detect_o` are low.
- R2: A measurement opens on any change of `tx_i`, rising or falling, seen at a clock edge while `cal_en` is high and no measurement is open. It closes at the first later edge where `rx_i` equals the new `tx_i` level. If it closes within THR = 2^CNT_W edges, no detect occurs and `slope_en` does not change.
- R3: If the measurement is still open at edge THR after the opening edge, `detect_o` is high for exactly one cycle following that edge.
- R4: Each detect taken while `cal_en` is high sets the lowest cleared bit of `slope_en` on the next edge. Bit 0 fills first, so the vector is always thermometer-coded (ones from bit 0 upward).
- R5: Changes of `tx_i` while a measurement is open are ignored. They neither restart nor queue a measurement.
- R6: If `rx_i` never reaches the new level, the measurement is force-closed at edge 4*THR and a second detect pulse fires there. A lost echo therefore adds two cells.
- R7: When all CELLS bits of `slope_en` are set, `saturated` is high, and further detects leave `slope_en` unchanged until reset.
- R8: While `cal_en` is low, `tx_i` changes open no measurement, `detect_o` stays low and `slope_en` holds.
- R9: Changes of `rx_i` while no measurement is open have no effect on `detect_o` or `slope_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_en | input | 1 | Calibration loop enable |
| tx_i | input | 1 | Transmit data as driven onto the bus |
| rx_i | input | 1 | Receive data as recovered from the bus |
| slope_en | output | CELLS | Thermometer-coded slope-current cell enables |
| saturated | output | 1 | All cells enabled |
| detect_o | output | 1 | One-cycle pulse per late or lost echo |

## Verification
Counting from the edge that opens a measurement, a late-echo detect is visible in the cycle after edge THR, a lost-echo detect in the cycle after edge 4*THR, and the matching cell appears one edge after each pulse. The bench drives inputs on falling edges and counts falling edges from the opening one, so it can tell which cycle each pulse falls in and compare that against the due cycle. The `slope_en` and `saturated` values are compared only after a settle window of 4*THR+4 cycles, once every pulse a measurement can produce has been absorbed. The expected cell count comes from a model that adds one step for a delay above THR, one more step for a lost echo, and stops at CELLS.

// File: rtl/slope_cal_pkg.sv
package slope_cal_pkg;

  // Number of clock cycles in a measurement threshold for a counter of w bits.
  function automatic int unsigned thr_cycles(input int unsigned w);
    return 32'd1 << w;
  endfunction

  // The timeout is a fixed multiple of the threshold.
  localparam int unsigned TMO_MULT_LOG2 = 2;

  typedef enum logic {
    MEAS_IDLE = 1'b0,
    MEAS_OPEN = 1'b1
  } meas_state_e;

endpackage

// File: rtl/edge_delay_detector.sv
module edge_delay_detector (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_en,
  input  logic tx_i,
  input  logic rx_i,
  input  logic force_close,
  output logic start_pulse,
  output logic echo_hit,
  output logic meas_busy
);
  import slope_cal_pkg::*;

  meas_state_e state_q;
  logic        tx_q;
  logic        want_q;
  logic        tx_change;

  assign tx_change   = tx_i ^ tx_q;
  assign start_pulse = (state_q == MEAS_IDLE) && cal_en && tx_change;
  assign echo_hit    = (state_q == MEAS_OPEN) && (rx_i == want_q);
  assign meas_busy   = (state_q == MEAS_OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MEAS_IDLE;
      tx_q    <= 1'b0;
      want_q  <= 1'b0;
    end else begin
      tx_q <= tx_i;
      unique case (state_q)
        MEAS_IDLE: begin
          if (start_pulse) begin
            state_q <= MEAS_OPEN;
            want_q  <= tx_i;
          end
        end
        MEAS_OPEN: begin
          if (echo_hit || force_close) begin
            state_q <= MEAS_IDLE;
          end
        end
        default: state_q <= MEAS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/overflow_sampler.sv
module overflow_sampler #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_pulse,
  input  logic meas_busy,
  input  logic echo_hit,
  output logic force_close,
  output logic late_det
);
  import slope_cal_pkg::*;

  localparam int unsigned TW      = CNT_W + TMO_MULT_LOG2;
  localparam logic [TW-1:0] OVF_AT = TW'(thr_cycles(CNT_W) - 1);
  localparam logic [TW-1:0] TMO_AT = {TW{1'b1}};

  logic [TW-1:0] cnt_q;
  logic          ovf_hit;
  logic          tmo_hit;

  assign ovf_hit     = meas_busy && (cnt_q == OVF_AT);
  assign tmo_hit     = meas_busy && (cnt_q == TMO_AT);
  assign force_close = tmo_hit && !echo_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      late_det <= 1'b0;
    end else begin
      if (start_pulse) begin
        cnt_q <= '0;
      end else if (meas_busy) begin
        cnt_q <= cnt_q + 1'b1;
      end
      late_det <= (ovf_hit || tmo_hit) && !echo_hit;
    end
  end

endmodule

// File: rtl/thermo_step_reg.sv
module thermo_step_reg #(
  parameter int unsigned CELLS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_en,
  input  logic             step,
  output logic [CELLS-1:0] cells,
  output logic             full
);

  logic advance;

  assign full    = &cells;
  assign advance = step && cal_en && !full;

  generate
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
      logic feed;
      if (i == 0) begin : g_head
        assign feed = 1'b1;
      end else begin : g_body
        assign feed = cells[i-1];
      end
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cells[i] <= 1'b0;
        end else if (advance) begin
          cells[i] <= feed;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/slope_delay_servo.sv
module slope_delay_servo #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned CELLS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_en,
  input  logic             tx_i,
  input  logic             rx_i,
  output logic [CELLS-1:0] slope_en,
  output logic             saturated,
  output logic             detect_o
);

  logic start_pulse;
  logic echo_hit;
  logic meas_busy;
  logic force_close;
  logic late_det;

  edge_delay_detector u_det (
    .clk         (clk),
    .rst_n       (rst_n),
    .cal_en      (cal_en),
    .tx_i        (tx_i),
    .rx_i        (rx_i),
    .force_close (force_close),
    .start_pulse (start_pulse),
    .echo_hit    (echo_hit),
    .meas_busy   (meas_busy)
  );

  overflow_sampler #(.CNT_W(CNT_W)) u_smp (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .meas_busy   (meas_busy),
    .echo_hit    (echo_hit),
    .force_close (force_close),
    .late_det    (late_det)
  );

  thermo_step_reg #(.CELLS(CELLS)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cal_en (cal_en),
    .step   (late_det),
    .cells  (slope_en),
    .full   (saturated)
  );

  assign detect_o = late_det;

endmodule

// File: rtl/slope_delay_servo_chk.sv
module slope_delay_servo_chk #(
  parameter int unsigned CELLS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cal_en,
  input logic             meas_busy,
  input logic [CELLS-1:0] slope_en,
  input logic             saturated,
  input logic             detect_o
);

  logic [CELLS-1:0] en_plus_one;
  assign en_plus_one = slope_en + 1'b1;

  // R4
  thermo_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_plus_one & slope_en) == '0);

  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slope_en) <= $countones($past(slope_en)) + 1);

  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_en |=> $stable(slope_en));

  // R7
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    saturated |=> saturated && (&slope_en));

  // R3
  detect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect_o |=> !detect_o);

  // R9
  detect_needs_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect_o |-> $past(meas_busy));

endmodule

bind slope_delay_servo slope_delay_servo_chk #(.CELLS(CELLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cal_en    (cal_en),
  .meas_busy (meas_busy),
  .slope_en  (slope_en),
  .saturated (saturated),
  .detect_o  (detect_o)
);

// File: tb/sim_slope_delay_servo.sv
`timescale 1ns/1ps
module sim_slope_delay_servo;

  localparam int CNT_W = 4;
  localparam int CELLS = 8;
  localparam int THR   = 1 << CNT_W;
  localparam int LIM   = 4 * THR + 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cal_en = 1'b0;
  logic             tx_i = 1'b0;
  logic             rx_i = 1'b0;
  logic [CELLS-1:0] slope_en;
  logic             saturated;
  logic             detect_o;

  int n_tests = 0;
  int n_fail  = 0;
  int model_steps = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  slope_delay_servo #(.CNT_W(CNT_W), .CELLS(CELLS)) u0 (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .tx_i(tx_i), .rx_i(rx_i),
    .slope_en(slope_en), .saturated(saturated), .detect_o(detect_o)
  );

  function automatic logic [CELLS-1:0] thermo(input int n);
    logic [CELLS-1:0] v = '0;
    for (int i = 0; i < CELLS; i++) if (i < n) v[i] = 1'b1;
    return v;
  endfunction

  function automatic int pulses_for(input int d, input bit lost, input bit en);
    int p = 0;
    if (!en) return 0;
    if (lost || d > THR) p++;
    if (lost) p++;
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tx_i = 1'b0; rx_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(slope_en == '0 && !saturated && !detect_o, "R1 in reset", int'(slope_en), 0);
    rst_n = 1'b1;
    model_steps = 0;
    @(negedge clk);
    chk(slope_en == '0 && !saturated && !detect_o, "R1 after reset", int'(slope_en), 0);
  endtask

  task automatic check_state(input string req);
    chk(slope_en == thermo(model_steps), req, int'(slope_en), int'(thermo(model_steps)));
    chk(saturated == (model_steps == CELLS), {req, " saturated"}, int'(saturated),
        int'(model_steps == CELLS));
  endtask

  // One measurement: d = echo delay in edges, lost = echo never comes,
  // glitch = tx toggles twice while the measurement is open.
  task automatic run_meas(input int d, input bit lost, input bit glitch,
                          input string req, input bit check_timing);
    int exp_p, seen, first_at, second_at;
    logic want;
    exp_p = pulses_for(d, lost, cal_en);
    seen = 0; first_at = -1; second_at = -1;
    @(negedge clk);
    tx_i = ~tx_i;
    want = tx_i;
    if (!lost && d == 0) rx_i = want;
    for (int j = 1; j <= LIM; j++) begin
      @(negedge clk);
      if (detect_o) begin
        seen++;
        if (first_at < 0) first_at = j; else second_at = j;
      end
      if (!lost && j == d) rx_i = want;
      if (glitch && (j == 2 || j == 3)) tx_i = ~tx_i;
    end
    rx_i = tx_i;
    @(negedge clk);
    chk(seen == exp_p, {req, " pulse count"}, seen, exp_p);
    if (check_timing && exp_p > 0)
      chk(first_at == THR + 1, {req, " first pulse cycle"}, first_at, THR + 1);
    if (check_timing && exp_p > 1)
      chk(second_at == 4 * THR + 1, {req, " timeout pulse cycle"}, second_at, 4 * THR + 1);
    model_steps = (model_steps + exp_p > CELLS) ? CELLS : model_steps + exp_p;
    check_state(req);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    do_reset();
    cal_en = 1'b1;

    // R2: echo exactly at the threshold, on a rising then a falling edge
    run_meas(THR, 1'b0, 1'b0, "R2 boundary rise", 1'b1);
    run_meas(THR, 1'b0, 1'b0, "R2 boundary fall", 1'b1);
    run_meas(0, 1'b0, 1'b0, "R2 zero delay", 1'b1);
    // R3 and R4: one edge past the threshold
    run_meas(THR + 1, 1'b0, 1'b0, "R3 late by one", 1'b1);
    run_meas(2 * THR, 1'b0, 1'b0, "R4 second step", 1'b1);
    // R5: tx glitches during a short measurement
    run_meas(THR / 2, 1'b0, 1'b1, "R5 glitch short", 1'b1);
    // R6: lost echo
    run_meas(0, 1'b1, 1'b0, "R6 lost echo", 1'b1);
    // R8: loop disabled
    cal_en = 1'b0;
    run_meas(3 * THR, 1'b0, 1'b0, "R8 disabled late", 1'b1);
    run_meas(0, 1'b1, 1'b0, "R8 disabled lost", 1'b1);
    cal_en = 1'b1;
    // R9: rx moves while idle
    repeat (2) begin
      @(negedge clk); rx_i = ~rx_i;
      repeat (THR + 3) begin
        @(negedge clk);
        chk(!detect_o, "R9 idle rx detect", int'(detect_o), 0);
      end
    end
    check_state("R9 idle rx cells");
    // R7: drive to saturation and beyond
    repeat (4) run_meas(0, 1'b1, 1'b0, "R7 fill", 1'b0);
    chk(saturated == 1'b1, "R7 saturated", int'(saturated), 1);
    run_meas(2 * THR, 1'b0, 1'b0, "R7 beyond full", 1'b1);

    // Random phase
    for (int r = 0; r < 4; r++) begin
      do_reset();
      cal_en = 1'b1;
      for (int k = 0; k < 12; k++) begin
        int d;
        bit lost, gl;
        d = int'($urandom % (2 * THR));
        lost = ($urandom % 12) == 0;
        gl = ($urandom % 4) == 0;
        cal_en = ($urandom % 6) != 0;
        run_meas(d, lost, gl && !lost && d > 4, "R2 R3 R4 random", 1'b1);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

endmodule